// File: doc/BRIEF.md
# Workspace-Pointer Context Switch Sequencer

This block performs a full register-context switch for a processor whose general registers live in ordinary memory. A workspace pointer (WP) holds the byte base of a sixteen-word register window, and register n sits at byte address WP + 2n. The block does not push the outgoing context onto a stack. It moves the window to a new base and records the outgoing WP, program counter and status word inside the new window. A later return request reads them back from there.

Three kinds of request enter a context. An interrupt level selects one of sixteen hardware vectors. A software trap number selects one of sixteen trap vectors and also carries an effective address for the handler. A call names an arbitrary vector address. Every vector is two words: the WP first, then the PC. The surrounding core supplies its current PC and status word with each request. The block keeps the live WP, PC and status word and presents them when it is idle. All memory traffic goes through a single word-wide port with a request/acknowledge handshake, one access at a time.

Top module: `ctxsw_seq`

## Requirements
- R1: In reset, and in the first cycle after reset is released, `busy` and `mem_req` are 0, `wp` equals the RESET_WP parameter (default 0x0100), and `pc` and `st` are 0.
- R2: An interrupt at level n reads the new WP from byte address 4n and then the new PC from 4n+2. Bit 0 of both fetched words is cleared before use.
- R3: A trap with number n reads its vector from byte address 0x40+4n (WP word) and then from 0x42+4n (PC word). Bit 0 is cleared on both words.
- R4: A call reads its vector from `call_vec` with bit 0 cleared, and then from that address plus 2.
- R5: Every memory access uses an address with bit 0 equal to 0. After the two vector reads come three writes to the new window. The first stores the old WP at new WP+26. The second stores the `pc_in` value sampled at acceptance at new WP+28. The third stores the `st_in` value sampled at acceptance at new WP+30. When the sequence ends, `wp` and `pc` hold the fetched values and `st` equals the sampled `st_in`.
- R6: A trap makes one more write after the status write: `trap_ea` (sampled at acceptance) goes to new WP+22. Interrupts and calls make exactly five accesses.
- R7: A return makes exactly three reads and no write. It reads current WP+30 into `st`, then WP+28 into `pc`, then WP+26 into `wp`. Bit 0 is cleared on the PC and WP words.
- R8: A command is accepted only when `busy` is 0. `busy` rises in the cycle after acceptance and falls in the cycle after the last acknowledge. Any command asserted while `busy` is 1 leaves the access sequence and the final context unchanged.
- R9: When several commands are asserted together, the interrupt wins over the trap, the trap wins over the call, and the call wins over the return.
- R10: While `mem_req` is 1 and `mem_ack` is 0, the address, the write enable and the write data hold steady into the next cycle. `mem_req` is 0 whenever `busy` is 0.
- R11: A nested sequence of context entries, followed by the same number of returns, restores the WP, PC and status word that were live before each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt context entry request |
| irq_lvl | input | 4 | Interrupt vector index |
| trap_req | input | 1 | Software trap request |
| trap_num | input | 4 | Trap vector index |
| trap_ea | input | 16 | Source effective address handed to the trap handler |
| call_req | input | 1 | Call through a vector at an arbitrary address |
| call_vec | input | 16 | Byte address of the call vector |
| ret_req | input | 1 | Return to the saved context |
| pc_in | input | 16 | Current program counter from the core |
| st_in | input | 16 | Current status word from the core |
| busy | output | 1 | Sequence in progress |
| wp | output | 16 | Live workspace pointer |
| pc | output | 16 | Program counter produced by the last switch |
| st | output | 16 | Status word produced by the last switch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The bench sweeps all sixteen interrupt levels and all sixteen trap numbers under acknowledge latencies of zero to two cycles. Every vector word in the table has bit 0 set, so a design that forgot to clear that bit would save into an odd window and report an odd PC. Each entry is followed by a return. A design that read WP before ST and PC on return would fetch the other two from the wrong window. A design that stored pc_in late, or that appended the link word to interrupts and calls, shows the wrong access count or the wrong data. Two further cases round out the sweep. Simultaneous requests check the fixed priority. Commands pulsed mid-sequence check that a busy block really ignores them: a design that did not would produce extra accesses or a different final context.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int WORD_W     = 16;
    localparam int N_VEC      = 16;
    localparam int IDX_W      = $clog2(N_VEC);
    localparam int SLOT_BYTES = 4;
    localparam int SLOT_SH    = $clog2(SLOT_BYTES);
    localparam int TRAP_BASE  = 64;

    localparam int R_LINK = 11;
    localparam int R_OWP  = 13;
    localparam int R_OPC  = 14;
    localparam int R_OST  = 15;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {K_IRQ, K_TRAP, K_CALL, K_RET} kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_VWP, S_VPC, S_SWP, S_SPC, S_SST, S_SEA, S_RST, S_RPC, S_RWP
    } step_e;

    typedef struct packed {
        word_t wp;
        word_t pc;
        word_t st;
    } ctx_t;

    typedef struct packed {
        logic  valid;
        kind_e kind;
        word_t vec;
    } cmd_t;

    function automatic word_t reg_addr(word_t base, int unsigned n);
        return base + word_t'(2 * n);
    endfunction

    function automatic word_t align(word_t w);
        return {w[WORD_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/ctxsw_cmdsel.sv
module ctxsw_cmdsel
    import ctxsw_pkg::*;
(
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_lvl,
    input  logic             trap_req,
    input  logic [IDX_W-1:0] trap_num,
    input  logic             call_req,
    input  word_t            call_vec,
    input  logic             ret_req,
    output cmd_t             cmd
);
    localparam word_t TRAP_OFS = word_t'(TRAP_BASE);

    always_comb begin
        cmd = '{valid: 1'b0, kind: K_RET, vec: '0};
        if (irq_req) begin
            cmd.valid = 1'b1;
            cmd.kind  = K_IRQ;
            cmd.vec   = word_t'(irq_lvl) << SLOT_SH;
        end else if (trap_req) begin
            cmd.valid = 1'b1;
            cmd.kind  = K_TRAP;
            cmd.vec   = TRAP_OFS + (word_t'(trap_num) << SLOT_SH);
        end else if (call_req) begin
            cmd.valid = 1'b1;
            cmd.kind  = K_CALL;
            cmd.vec   = align(call_vec);
        end else if (ret_req) begin
            cmd.valid = 1'b1;
            cmd.kind  = K_RET;
        end
    end

endmodule

// File: rtl/ctxsw_ctrl.sv
module ctxsw_ctrl
    import ctxsw_pkg::*;
#(
    parameter word_t RESET_WP = 16'h0100
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    input  word_t trap_ea,
    input  word_t pc_in,
    input  word_t st_in,
    output logic  busy,
    output ctx_t  ctx,
    output logic  mem_req,
    output logic  mem_we,
    output word_t mem_addr,
    output word_t mem_wdata,
    input  word_t mem_rdata,
    input  logic  mem_ack
);
    step_e step;
    kind_e kind_q;
    ctx_t  cur, old_q;
    word_t ea_q, vec_q;
    logic  accept;

    assign busy    = (step != S_IDLE);
    assign accept  = !busy && cmd.valid;
    assign mem_req = busy;
    assign ctx     = cur;

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (step)
            S_VWP: mem_addr = vec_q;
            S_VPC: mem_addr = vec_q + word_t'(2);
            S_SWP: begin mem_we = 1'b1; mem_addr = reg_addr(cur.wp, R_OWP);  mem_wdata = old_q.wp; end
            S_SPC: begin mem_we = 1'b1; mem_addr = reg_addr(cur.wp, R_OPC);  mem_wdata = old_q.pc; end
            S_SST: begin mem_we = 1'b1; mem_addr = reg_addr(cur.wp, R_OST);  mem_wdata = old_q.st; end
            S_SEA: begin mem_we = 1'b1; mem_addr = reg_addr(cur.wp, R_LINK); mem_wdata = ea_q;     end
            S_RST: mem_addr = reg_addr(cur.wp, R_OST);
            S_RPC: mem_addr = reg_addr(cur.wp, R_OPC);
            S_RWP: mem_addr = reg_addr(cur.wp, R_OWP);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= S_IDLE;
            kind_q <= K_RET;
            cur    <= '{wp: RESET_WP, pc: '0, st: '0};
            old_q  <= '0;
            ea_q   <= '0;
            vec_q  <= '0;
        end else if (accept) begin
            kind_q <= cmd.kind;
            vec_q  <= cmd.vec;
            ea_q   <= trap_ea;
            old_q  <= '{wp: cur.wp, pc: pc_in, st: st_in};
            if (cmd.kind == K_RET) begin
                step <= S_RST;
            end else begin
                step   <= S_VWP;
                cur.st <= st_in;
            end
        end else if (busy && mem_ack) begin
            unique case (step)
                S_VWP: begin cur.wp <= align(mem_rdata); step <= S_VPC; end
                S_VPC: begin cur.pc <= align(mem_rdata); step <= S_SWP; end
                S_SWP: step <= S_SPC;
                S_SPC: step <= S_SST;
                S_SST: step <= (kind_q == K_TRAP) ? S_SEA : S_IDLE;
                S_SEA: step <= S_IDLE;
                S_RST: begin cur.st <= mem_rdata;        step <= S_RPC;  end
                S_RPC: begin cur.pc <= align(mem_rdata); step <= S_RWP;  end
                S_RWP: begin cur.wp <= align(mem_rdata); step <= S_IDLE; end
                default: step <= S_IDLE;
            endcase
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && cur.wp == RESET_WP)); // R1
    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]); // R5
    AST_WP_EVEN: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cur.wp[0]); // R7
    AST_RET_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (busy && kind_q == K_RET) |-> !mem_we); // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd.valid) |=> busy); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R10

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
    import ctxsw_pkg::*;
#(
    parameter logic [15:0] RESET_WP = 16'h0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_lvl,
    input  logic             trap_req,
    input  logic [IDX_W-1:0] trap_num,
    input  logic [15:0]      trap_ea,
    input  logic             call_req,
    input  logic [15:0]      call_vec,
    input  logic             ret_req,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      st_in,
    output logic             busy,
    output logic [15:0]      wp,
    output logic [15:0]      pc,
    output logic [15:0]      st,
    output logic             mem_req,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_ack
);
    cmd_t cmd;
    ctx_t ctx;

    ctxsw_cmdsel u_sel (
        .irq_req  (irq_req),
        .irq_lvl  (irq_lvl),
        .trap_req (trap_req),
        .trap_num (trap_num),
        .call_req (call_req),
        .call_vec (call_vec),
        .ret_req  (ret_req),
        .cmd      (cmd)
    );

    ctxsw_ctrl #(.RESET_WP(RESET_WP)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .trap_ea   (trap_ea),
        .pc_in     (pc_in),
        .st_in     (st_in),
        .busy      (busy),
        .ctx       (ctx),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    assign wp = ctx.wp;
    assign pc = ctx.pc;
    assign st = ctx.st;

endmodule

// File: tb/ctxsw_seq_test.sv
`timescale 1ns/1ps
module ctxsw_seq_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, irq_req, trap_req, call_req, ret_req, busy, mem_req, mem_we, mem_ack;
    logic [3:0]  irq_lvl, trap_num;
    logic [15:0] trap_ea, call_vec, pc_in, st_in, wp, pc, st, mem_addr, mem_wdata, mem_rdata;

    ctxsw_seq uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl), .trap_req(trap_req),
        .trap_num(trap_num), .trap_ea(trap_ea), .call_req(call_req), .call_vec(call_vec),
        .ret_req(ret_req), .pc_in(pc_in), .st_in(st_in), .busy(busy), .wp(wp), .pc(pc),
        .st(st), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int nchk = 0, nerr = 0;
    logic [15:0] mem [0:1023];
    int lat = 0, waitc = 0, nlog = 0;
    logic [15:0] log_a [0:7];
    logic [15:0] log_d [0:7];
    logic        log_w [0:7];
    logic [15:0] prev_a;
    logic        prev_w;

    // model of the context history for round-trip checks
    logic [15:0] sk_wp [0:15];
    logic [15:0] sk_pc [0:15];
    logic [15:0] sk_st [0:15];
    int sp = 0;
    logic [15:0] m_wp = 16'h0100;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural word memory, driven on the falling edge
    always @(negedge clk) begin
        if (mem_req) begin
            if (waitc > 0) begin
                chk("R10 held request stable", {15'd0, prev_w, prev_a}, {15'd0, mem_we, mem_addr});
            end
            if (waitc >= lat) begin
                mem_ack = 1'b1;
                waitc = 0;
                if (nlog < 8) begin
                    log_a[nlog] = mem_addr;
                    log_w[nlog] = mem_we;
                    log_d[nlog] = mem_we ? mem_wdata : 16'h0;
                end
                nlog++;
                if (mem_we) mem[mem_addr[10:1]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[10:1]];
            end else begin
                mem_ack = 1'b0;
                waitc++;
                prev_a = mem_addr;
                prev_w = mem_we;
            end
        end else begin
            mem_ack = 1'b0;
            waitc = 0;
        end
    end

    task automatic clear_cmds();
        irq_req = 0; trap_req = 0; call_req = 0; ret_req = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) chk({tag, " watchdog"}, 1, 0);
    endtask

    // issue a command set; expected results follow the priority order of R9
    task automatic issue(input bit iq, input int lv, input bit tq, input int tn,
                         input bit cq, input logic [15:0] cv, input bit rq,
                         input logic [15:0] ea, input logic [15:0] pci,
                         input logic [15:0] sti, input bit poke, input string tag);
        logic [15:0] va, nwp, npc;
        int nacc;
        bit is_ret, is_trap;
        is_ret = 0; is_trap = 0;
        if (iq)      va = 16'(lv * 4);
        else if (tq) begin va = 16'(64 + tn * 4); is_trap = 1; end
        else if (cq) va = cv & 16'hFFFE;
        else begin va = 0; is_ret = 1; end
        @(negedge clk);
        irq_req = iq; irq_lvl = 4'(lv); trap_req = tq; trap_num = 4'(tn);
        call_req = cq; call_vec = cv; ret_req = rq;
        trap_ea = ea; pc_in = pci; st_in = sti;
        nlog = 0;
        @(negedge clk);
        chk({tag, " R8 busy after accept"}, {31'd0, busy}, 1);
        if (poke) begin
            irq_req = 1; ret_req = 1; trap_req = 1; call_req = 1;
            pc_in = 16'h5555; st_in = 16'hAAAA; trap_ea = 16'h1234;
            @(negedge clk);
        end
        clear_cmds();
        wait_idle(tag);
        if (!is_ret) begin
            nwp  = mem[va[10:1]] & 16'hFFFE;
            npc  = mem[va[10:1] + 10'd1] & 16'hFFFE;
            nacc = is_trap ? 6 : 5;
            chk({tag, " R6 access count"}, nlog, nacc);
            chk({tag, " R2/R3/R4 vector WP address"}, {log_w[0], log_a[0]}, {1'b0, va});
            chk({tag, " R2/R3/R4 vector PC address"}, {log_w[1], log_a[1]}, {1'b0, va + 16'd2});
            chk({tag, " R5 save old WP"}, {log_w[2], log_a[2], log_d[2]}, {1'b1, nwp + 16'd26, m_wp});
            chk({tag, " R5 save old PC"}, {log_w[3], log_a[3], log_d[3]}, {1'b1, nwp + 16'd28, pci});
            chk({tag, " R5 save old ST"}, {log_w[4], log_a[4], log_d[4]}, {1'b1, nwp + 16'd30, sti});
            if (is_trap)
                chk({tag, " R6 link word"}, {log_w[5], log_a[5], log_d[5]}, {1'b1, nwp + 16'd22, ea});
            chk({tag, " R5 new WP"}, wp, nwp);
            chk({tag, " R5 new PC"}, pc, npc);
            chk({tag, " R5 status kept"}, st, sti);
            sk_wp[sp] = m_wp; sk_pc[sp] = pci; sk_st[sp] = sti; sp++;
            m_wp = nwp;
        end else begin
            sp--;
            chk({tag, " R7 access count"}, nlog, 3);
            chk({tag, " R7 read ST slot"}, {log_w[0], log_a[0]}, {1'b0, m_wp + 16'd30});
            chk({tag, " R7 read PC slot"}, {log_w[1], log_a[1]}, {1'b0, m_wp + 16'd28});
            chk({tag, " R7 read WP slot"}, {log_w[2], log_a[2]}, {1'b0, m_wp + 16'd26});
            chk({tag, " R11 restored WP"}, wp, sk_wp[sp]);
            chk({tag, " R11 restored PC"}, pc, sk_pc[sp]);
            chk({tag, " R11 restored ST"}, st, sk_st[sp]);
            m_wp = sk_wp[sp];
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        for (int n = 0; n < 16; n++) begin
            mem[2*n]        = 16'(16'h0201 + 32 * n);
            mem[2*n + 1]    = 16'(16'h1001 + 4 * n);
            mem[32 + 2*n]   = 16'(16'h0401 + 32 * n);
            mem[33 + 2*n]   = 16'(16'h2001 + 2 * n);
        end
        mem[10'h300] = 16'h0681; mem[10'h301] = 16'h3001;
        mem[10'h302] = 16'h06A1; mem[10'h303] = 16'h3101;
        mem_ack = 0; mem_rdata = 0;
        clear_cmds();
        irq_lvl = 0; trap_num = 0; trap_ea = 0; call_vec = 0; pc_in = 0; st_in = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy}, 0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 0);
        chk("R1 wp after reset", wp, 16'h0100);
        chk("R1 pc after reset", pc, 0);
        chk("R1 st after reset", st, 0);

        for (int n = 0; n < 16; n++) begin
            lat = n % 3;
            issue(1, n, 0, 0, 0, 0, 0, 0, 16'(16'h8000 + 2*n), 16'(16'hC000 + n), 0, "R2 irq");
            issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 ret irq");
        end
        for (int n = 0; n < 16; n++) begin
            lat = (n + 1) % 3;
            issue(0, 0, 1, n, 0, 0, 0, 16'(16'hE001 + 3*n), 16'(16'h9000 + 4*n), 16'(16'h0F00 + n), 0, "R3 trap");
            issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 ret trap");
        end

        lat = 1;
        issue(0, 0, 0, 0, 1, 16'h0600, 0, 0, 16'h4440, 16'h0011, 0, "R4 call outer");
        issue(0, 0, 0, 0, 1, 16'h0605, 0, 0, 16'h4560, 16'h0022, 0, "R4 call inner odd address");
        issue(0, 0, 1, 9, 0, 0, 0, 16'hBEEF, 16'h4600, 16'h0033, 0, "R11 trap nested");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 ret level3");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 ret level2");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 ret level1");
        chk("R11 home WP", wp, 16'h0100);

        lat = 0;
        issue(1, 5, 1, 7, 1, 16'h0600, 1, 16'h0707, 16'h7000, 16'h0044, 0, "R9 irq wins");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 ret");
        issue(0, 0, 1, 7, 1, 16'h0600, 1, 16'h0707, 16'h7010, 16'h0055, 0, "R9 trap wins");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 ret");
        issue(0, 0, 0, 0, 1, 16'h0600, 1, 0, 16'h7020, 16'h0066, 0, "R9 call wins");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 ret");

        lat = 2;
        issue(0, 0, 0, 0, 1, 16'h0604, 0, 0, 16'h7100, 16'h0077, 1, "R8 ignore while busy call");
        issue(0, 0, 1, 3, 0, 0, 0, 16'h0ACE, 16'h7200, 16'h0088, 1, "R8 ignore while busy trap");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R8 ignore while busy ret");
        issue(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 final ret");
        chk("R8 home WP", wp, 16'h0100);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule